// File: doc/BRIEF.md
# Line-Fill Burst Resume Controller

This block is a bus-master sequencer that fetches one 16-byte cache-style line as a burst of four 32-bit data phases on a simplified PCI-style parallel bus. A requester hands it a byte address and a start pulse. The block widens the request to a whole-line prefetch, arbitrates for the bus, and writes each dword into a line buffer as its data phase completes. It reports completion only once every dword of the line is present.

A target may end a burst early. When a target stops before any dword of the current attempt has moved, the block treats it as a retry. When a target stops after at least one dword has moved, the block treats it as a disconnect. In both cases the block releases the bus for one clock, arbitrates again, and resumes at the first dword that is still missing. The new burst covers only the dwords that are still owed. Retries are counted over the life of one request, and a fill that needs too many retries is abandoned with an error pulse. Disconnects do not count toward that limit, because each one delivers data.

Top module: `lfr_top`

## Requirements
- R1: While reset is asserted and after reset is released, with no request, `busReq`, `busFrame`, `busIrdy`, `lbWrEn`, `lineValid`, `fillError` and `busy` are all low.
- R2: A `reqStart` pulse seen while idle raises `busy` and `busReq` in the next cycle. The clock after `busGnt` is sampled high is a single address cycle, with `busFrame` high and `busIrdy` low. The first address issued is `reqAddr` with its low 4 bits cleared.
- R3: A data phase completes only in a cycle where `busIrdy`, `busTrdy` and `busDevsel` are all high. In that same cycle `lbWrEn` is high, `lbWrIdx` holds the dword index (0..3) and `lbWrData` equals `busRdData`. In any other cycle `lbWrEn` is low.
- R4: During data cycles `busIrdy` is high. `busFrame` stays high while two or more dwords are still owed, and it is low in the cycle that carries the last owed dword.
- R5: In the cycle after `busStop` is sampled high in a data cycle, `busReq`, `busFrame` and `busIrdy` are all low. This lasts exactly one cycle. If the line is incomplete and not aborted, `busReq` is high again in the following cycle.
- R6: A stop seen before any data phase of the current attempt completes is a retry. The next address cycle reissues the same dword address.
- R7: After a disconnect, the next address cycle issues line base + 4 × (index of the first missing dword). No dword index is written twice within one fill.
- R8: `lineValid` is a one-cycle pulse in the cycle after the final data phase completes. If the final dword arrives together with a stop, the pulse comes after the one-cycle release. `busy` is low in the cycle after the pulse.
- R9: Retries are counted from the request. A fill survives exactly RETRY_LIMIT (default 16) retries. On the retry that exceeds the limit, `fillError` pulses for one cycle after the release cycle, `lineValid` stays low, and the block returns to idle. Disconnects do not add to the count.
- R10: `reqStart` has no effect while `busy` is high. Addresses issued and the line completed belong to the request that was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqStart | input | 1 | Start a line fill (accepted when idle) |
| reqAddr | input | 32 | Byte address inside the wanted line |
| busy | output | 1 | A fill is in progress |
| lineValid | output | 1 | One-cycle pulse: the line buffer holds the whole line |
| fillError | output | 1 | One-cycle pulse: fill abandoned after too many retries |
| busReq | output | 1 | Bus request to the arbiter |
| busGnt | input | 1 | Bus grant from the arbiter |
| busFrame | output | 1 | Transaction frame, high while more data phases follow |
| busIrdy | output | 1 | Initiator ready during data cycles |
| busTrdy | input | 1 | Target ready |
| busStop | input | 1 | Target requests termination |
| busDevsel | input | 1 | Target has claimed the cycle |
| busAddr | output | 32 | Burst start address, valid in the address cycle |
| busRdData | input | 32 | Read data from the target |
| lbWrEn | output | 1 | Line-buffer write strobe |
| lbWrIdx | output | 2 | Dword index within the line |
| lbWrData | output | 32 | Dword written to the line buffer |

## Verification
The line-buffer write port is combinational from the target handshake, so it is checked in the same cycle, shortly after the bench drives `busTrdy`/`busDevsel`. Registered outputs are sampled on the falling edge. The address cycle is checked one cycle after a grant. The bus release is checked one cycle after a stop, and the re-request one cycle after that. `lineValid` is checked one cycle after the last handshake, or two cycles after a stop that carried the last dword. `fillError` is checked in the cycle following the release that exceeded the limit. A bench-side model of dwords received and retries counted predicts each of these points, so every check samples at its computed cycle rather than waiting for an event.

// File: rtl/lfr_pkg.sv
package lfr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ARB, ST_ADDR, ST_DATA, ST_BACKOFF, ST_DONE, ST_FAIL
  } lfrState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;       // capture a new line request
    logic startAttempt;  // an address cycle is issued
    logic beat;          // a data phase completes this cycle
    logic countRetry;    // a stop ended an attempt with no data
  } lfrStrobe_t;
endpackage

// File: rtl/lfr_datapath.sv
module lfr_datapath
  import lfr_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int LINE_DWORDS = 4,
  parameter int RETRY_LIMIT = 16
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  lfrStrobe_t                        strobe,
  input  logic [ADDR_W-1:0]                 reqAddr,
  input  logic [DATA_W-1:0]                 busRdData,
  output logic [ADDR_W-1:0]                 busAddr,
  output logic                              lbWrEn,
  output logic [$clog2(LINE_DWORDS)-1:0]    lbWrIdx,
  output logic [DATA_W-1:0]                 lbWrData,
  output logic                              lineFull,
  output logic                              lastOwed,
  output logic                              progress,
  output logic                              retryOver
);
  localparam int IDX_W      = $clog2(LINE_DWORDS);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int WORD_OFF_W = $clog2(WORD_BYTES);
  localparam int LINE_BYTES = LINE_DWORDS * WORD_BYTES;
  localparam int MISS_W     = $clog2(LINE_DWORDS + 1);
  localparam int CNT_W      = $clog2(RETRY_LIMIT + 2);

  logic [ADDR_W-1:0]      baseQ;
  logic [LINE_DWORDS-1:0] validMap;
  logic [IDX_W-1:0]       beatIdx;
  logic [IDX_W-1:0]       firstMissing;
  logic [MISS_W-1:0]      missingCount;
  logic [CNT_W-1:0]       retryCnt;
  logic                   progressQ;

  // first dword not yet received
  always_comb begin
    logic found;
    found        = 1'b0;
    firstMissing = '0;
    for (int i = 0; i < LINE_DWORDS; i++) begin
      if (!validMap[i] && !found) begin
        firstMissing = IDX_W'(i);
        found        = 1'b1;
      end
    end
  end

  always_comb begin
    missingCount = '0;
    for (int i = 0; i < LINE_DWORDS; i++)
      if (!validMap[i]) missingCount = missingCount + MISS_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ     <= '0;
      validMap  <= '0;
      beatIdx   <= '0;
      retryCnt  <= '0;
      progressQ <= 1'b0;
    end else begin
      if (strobe.loadReq) begin
        baseQ     <= reqAddr & ~ADDR_W'(LINE_BYTES - 1);
        validMap  <= '0;
        retryCnt  <= '0;
        progressQ <= 1'b0;
      end
      if (strobe.startAttempt) begin
        beatIdx   <= firstMissing;
        progressQ <= 1'b0;
      end
      if (strobe.beat) begin
        validMap[beatIdx] <= 1'b1;
        beatIdx           <= beatIdx + IDX_W'(1);
        progressQ         <= 1'b1;
      end
      if (strobe.countRetry && retryCnt != CNT_W'(RETRY_LIMIT + 1))
        retryCnt <= retryCnt + CNT_W'(1);
    end
  end

  assign busAddr   = baseQ | (ADDR_W'(firstMissing) << WORD_OFF_W);
  assign lbWrEn    = strobe.beat;
  assign lbWrIdx   = beatIdx;
  assign lbWrData  = busRdData;
  assign lineFull  = &validMap;
  assign lastOwed  = (missingCount == MISS_W'(1));
  assign progress  = progressQ;
  assign retryOver = (retryCnt > CNT_W'(RETRY_LIMIT));

  // a dword already received is never written again in the same fill
  assert_no_rewrite_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.beat |-> !validMap[beatIdx]);

  // received dwords stay received until a new request
  assert_map_keeps_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadReq |=> ((validMap & $past(validMap)) == $past(validMap)));
endmodule

// File: rtl/lfr_control.sv
module lfr_control
  import lfr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqStart,
  input  logic       busGnt,
  input  logic       busTrdy,
  input  logic       busStop,
  input  logic       busDevsel,
  input  logic       lineFull,
  input  logic       lastOwed,
  input  logic       progress,
  input  logic       retryOver,
  output lfrStrobe_t strobe,
  output logic       busReq,
  output logic       busFrame,
  output logic       busIrdy,
  output logic       lineValid,
  output logic       fillError,
  output logic       busy
);
  lfrState_t state, nextState;
  logic      beatNow;

  assign beatNow = busDevsel && busTrdy;

  always_comb begin
    nextState = state;
    strobe    = '0;
    busReq    = 1'b0;
    busFrame  = 1'b0;
    busIrdy   = 1'b0;
    lineValid = 1'b0;
    fillError = 1'b0;
    unique case (state)
      ST_IDLE: if (reqStart) begin
        strobe.loadReq = 1'b1;
        nextState      = ST_ARB;
      end
      ST_ARB: begin
        busReq = 1'b1;
        if (busGnt) nextState = ST_ADDR;
      end
      ST_ADDR: begin
        busReq              = 1'b1;
        busFrame            = 1'b1;
        strobe.startAttempt = 1'b1;
        nextState           = ST_DATA;
      end
      ST_DATA: begin
        busReq      = 1'b1;
        busFrame    = !lastOwed;
        busIrdy     = 1'b1;
        strobe.beat = beatNow;
        if (busStop) begin
          strobe.countRetry = !(progress || beatNow);
          nextState         = ST_BACKOFF;
        end else if (beatNow && lastOwed) begin
          nextState = ST_DONE;
        end
      end
      ST_BACKOFF: begin
        if (lineFull)       nextState = ST_DONE;
        else if (retryOver) nextState = ST_FAIL;
        else                nextState = ST_ARB;
      end
      ST_DONE: begin
        lineValid = 1'b1;
        nextState = ST_IDLE;
      end
      ST_FAIL: begin
        fillError = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign busy = (state != ST_IDLE);

  // bus released in the cycle after a target stop
  assert_release_after_stop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busIrdy && busStop) |=> (!busReq && !busFrame && !busIrdy));

  // an address cycle is always followed by a data cycle
  assert_addr_then_data_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busFrame && !busIrdy) |=> busIrdy);

  // completion only reported with every dword present
  assert_valid_needs_full_R8: assert property (@(posedge clk) disable iff (!rstN)
    lineValid |-> lineFull);

  // never completion and abort together, and abort only past the limit
  assert_error_after_limit_R9: assert property (@(posedge clk) disable iff (!rstN)
    fillError |-> (retryOver && !lineFull));
endmodule

// File: rtl/lfr_top.sv
module lfr_top
  import lfr_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int LINE_DWORDS = 4,
  parameter int RETRY_LIMIT = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           reqStart,
  input  logic [ADDR_W-1:0]              reqAddr,
  output logic                           busy,
  output logic                           lineValid,
  output logic                           fillError,
  output logic                           busReq,
  input  logic                           busGnt,
  output logic                           busFrame,
  output logic                           busIrdy,
  input  logic                           busTrdy,
  input  logic                           busStop,
  input  logic                           busDevsel,
  output logic [ADDR_W-1:0]              busAddr,
  input  logic [DATA_W-1:0]              busRdData,
  output logic                           lbWrEn,
  output logic [$clog2(LINE_DWORDS)-1:0] lbWrIdx,
  output logic [DATA_W-1:0]              lbWrData
);
  lfrStrobe_t strobe;
  logic lineFull, lastOwed, progress, retryOver;

  lfr_control u_ctrl (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .busGnt(busGnt),
    .busTrdy(busTrdy), .busStop(busStop), .busDevsel(busDevsel),
    .lineFull(lineFull), .lastOwed(lastOwed), .progress(progress),
    .retryOver(retryOver), .strobe(strobe), .busReq(busReq),
    .busFrame(busFrame), .busIrdy(busIrdy), .lineValid(lineValid),
    .fillError(fillError), .busy(busy)
  );

  lfr_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .LINE_DWORDS(LINE_DWORDS), .RETRY_LIMIT(RETRY_LIMIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .busRdData(busRdData), .busAddr(busAddr), .lbWrEn(lbWrEn),
    .lbWrIdx(lbWrIdx), .lbWrData(lbWrData), .lineFull(lineFull),
    .lastOwed(lastOwed), .progress(progress), .retryOver(retryOver)
  );
endmodule

// File: tb/tb_lfr_top.sv
`timescale 1ns/1ps
module tb_lfr_top;
  localparam int LIMIT = 16;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqStart;
  logic [31:0] reqAddr;
  logic        busy, lineValid, fillError;
  logic        busReq, busGnt, busFrame, busIrdy, busTrdy, busStop, busDevsel;
  logic [31:0] busAddr, busRdData, lbWrData;
  logic        lbWrEn;
  logic [1:0]  lbWrIdx;

  int nCmp = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  lfr_top dut (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .reqAddr(reqAddr),
    .busy(busy), .lineValid(lineValid), .fillError(fillError),
    .busReq(busReq), .busGnt(busGnt), .busFrame(busFrame), .busIrdy(busIrdy),
    .busTrdy(busTrdy), .busStop(busStop), .busDevsel(busDevsel),
    .busAddr(busAddr), .busRdData(busRdData), .lbWrEn(lbWrEn),
    .lbWrIdx(lbWrIdx), .lbWrData(lbWrData)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] patData(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5A3C_96E1;
  endfunction

  task automatic clearTarget();
    busGnt = 0; busTrdy = 0; busStop = 0; busDevsel = 0; busRdData = '0;
  endtask

  // mode 0: random, 1: retry every attempt, 2: one disconnect then LIMIT retries
  task automatic runFill(input logic [31:0] addr, input int mode, input bit poke);
    logic [31:0] base;
    int got, retries, attempt;
    base = addr & 32'hFFFF_FFF0;
    got = 0; retries = 0; attempt = 0;
    reqAddr = addr; reqStart = 1;
    @(negedge clk); reqStart = 0;
    check("R2", "busy after start", {31'b0, busy}, 1);
    check("R2", "req after start", {31'b0, busReq}, 1);
    forever begin
      int kind, k, delivered, gd;
      bit stopData, stopped;
      gd = $urandom_range(0, 3);
      repeat (gd) begin
        check("R5", "req held awaiting grant", {31'b0, busReq}, 1);
        check("R2", "no frame before grant", {31'b0, busFrame}, 0);
        @(negedge clk);
      end
      busGnt = 1;
      @(negedge clk); busGnt = 0;
      check("R2", "address cycle frame", {31'b0, busFrame}, 1);
      check("R2", "address cycle irdy", {31'b0, busIrdy}, 0);
      check(retries > 0 ? "R6" : "R7", "resume address", busAddr, base + 32'(4 * got));
      if (poke) begin reqStart = 1; reqAddr = addr ^ 32'h0000_0140; end
      @(negedge clk); reqStart = 0;
      // plan this attempt
      if (mode == 1) kind = 0;
      else if (mode == 2) kind = (attempt == 0) ? 1 : (retries < LIMIT ? 0 : 2);
      else begin
        kind = $urandom_range(0, 3);
        if (kind == 3) kind = 2;
        if (kind == 0 && retries >= LIMIT) kind = 2;
      end
      k = (kind == 1) ? $urandom_range(1, 4 - got) : 0;
      stopData = (mode == 2) ? 1'b0 : 1'($urandom_range(0, 1));
      if (kind == 1 && !stopData && k == 4 - got) begin
        if (k > 1) k = k - 1; else stopData = 1;
      end
      delivered = 0; stopped = 0;
      while (1) begin
        check("R4", "irdy in data cycle", {31'b0, busIrdy}, 1);
        check("R4", "frame vs owed", {31'b0, busFrame}, (4 - got) > 1 ? 1 : 0);
        if (kind == 0 || (kind == 1 && !stopData && delivered == k)) begin
          busStop = 1; busTrdy = 0; busDevsel = 1'($urandom_range(0, 1));
          #1 check("R3", "no write on stop without data", {31'b0, lbWrEn}, 0);
          @(negedge clk); clearTarget();
          if (delivered == 0) retries++;
          stopped = 1;
          break;
        end
        if ($urandom_range(0, 3) == 0) begin
          busTrdy = 1'($urandom_range(0, 1)); busDevsel = !busTrdy;
          #1 check("R3", "no write in wait cycle", {31'b0, lbWrEn}, 0);
          @(negedge clk); clearTarget();
          continue;
        end
        busTrdy = 1; busDevsel = 1;
        busRdData = patData(base + 32'(4 * got));
        busStop = (kind == 1 && stopData && delivered == k - 1);
        #1;
        check("R3", "write strobe", {31'b0, lbWrEn}, 1);
        check("R7", "write index", {30'b0, lbWrIdx}, 32'(got));
        check("R3", "write data", lbWrData, patData(base + 32'(4 * got)));
        stopped = busStop;
        got++; delivered++;
        @(negedge clk); clearTarget();
        if (stopped) break;
        if (got == 4) break;
      end
      if (!stopped) begin
        check("R8", "line valid after last phase", {31'b0, lineValid}, 1);
        @(negedge clk);
        check("R8", "idle after completion", {31'b0, busy}, 0);
        check("R8", "valid is a pulse", {31'b0, lineValid}, 0);
        return;
      end
      check("R5", "req released", {31'b0, busReq}, 0);
      check("R5", "frame released", {31'b0, busFrame}, 0);
      check("R5", "irdy released", {31'b0, busIrdy}, 0);
      @(negedge clk);
      if (got == 4) begin
        check("R8", "line valid after release", {31'b0, lineValid}, 1);
        @(negedge clk);
        check("R8", "idle after completion", {31'b0, busy}, 0);
        return;
      end
      if (retries > LIMIT) begin
        check("R9", "error pulse", {31'b0, fillError}, 1);
        check("R9", "no line valid on abort", {31'b0, lineValid}, 0);
        @(negedge clk);
        check("R9", "idle after abort", {31'b0, busy}, 0);
        check("R9", "error is a pulse", {31'b0, fillError}, 0);
        return;
      end
      check("R9", "no early error", {31'b0, fillError}, 0);
      check("R5", "re-request after release", {31'b0, busReq}, 1);
      attempt++;
    end
  endtask

  initial begin
    void'($urandom(32'd20240607));
    rstN = 0; reqStart = 0; reqAddr = '0; clearTarget();
    repeat (3) @(negedge clk);
    check("R1", "req in reset", {31'b0, busReq}, 0);
    check("R1", "busy in reset", {31'b0, busy}, 0);
    rstN = 1;
    @(negedge clk);
    check("R1", "idle outputs", {25'b0, busReq, busFrame, busIrdy, lbWrEn,
                                 lineValid, fillError, busy}, 0);
    // directed: complete retry exhaustion
    runFill(32'h1000_0A37, 1, 0);
    // directed: disconnect does not count toward the limit
    runFill(32'h2000_00F4, 2, 0);
    // directed: start pokes while busy are ignored (R10)
    runFill(32'h3000_1238, 0, 1);
    check("R10", "no stray start after poked fill", {31'b0, busy}, 0);
    @(negedge clk);
    check("R10", "still idle", {31'b0, busy}, 0);
    // random fills
    for (int n = 0; n < 60; n++) runFill($urandom, 0, 1'(n % 7 == 3));
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nCmp++; nBad++;
      $display("FAIL R8 watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule